// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits between a serial-bus slave decoder and a small byte-wide memory array. A write transfer opens with a start strobe that carries a word address. The block latches the page part of that address and the byte offset inside the page. Each data strobe that follows places its byte in a page-sized holding buffer at the current offset. The offset then advances modulo the page size, and the page part never changes. If more bytes arrive than the page holds, the later ones overwrite the earlier ones.

When the transfer is closed by a stop strobe and at least one byte is held, the block starts a self-timed programming cycle. The length of this cycle is a parameter counted in clocks. A busy flag is high for the whole cycle. In the final clock of the cycle, every loaded lane is written into the array at once through per-lane write enables. While busy is high, all requests are ignored.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, busy is 0 and every lane write enable is 0.
- R2: A start strobe latches page = address[6:2] and offset = address[1:0]. The k-th accepted byte goes to lane (offset + k) mod 4. Lane i is written at array address {page, i}, with its byte on mem_wdata[8*i+7:8*i]. The page output stays at the latched page.
- R3: When more than 4 bytes are sent before stop, the offset wraps, and a later byte replaces the earlier byte in the same lane.
- R4: No lane write enable is raised before stop. Busy rises in the clock after a stop strobe that finds bytes held.
- R5: Busy stays high for exactly PROG_CYCLES clocks. All lane writes happen together in a single clock, which is the last busy clock.
- R6: Only lanes that received a byte in the current transfer have their write enable raised. A lane mask bit i corresponds to mem_we[i].
- R7: A stop strobe with no bytes held starts no programming cycle. Busy stays 0 and nothing is written.
- R8: Start, data and stop strobes that arrive while busy is high have no effect on the held bytes, the lane mask, the page or the cycle length, and they leave nothing pending afterwards.
- R9: Data strobes that arrive without an open transfer are ignored. A new start strobe during an open transfer discards the bytes held so far.
- R10: A single-byte write follows the same path and writes exactly one lane.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_start | input | 1 | Opens a write transfer; one-clock strobe |
| wr_addr | input | 7 | Word address qualified by wr_start |
| byte_vld | input | 1 | One data byte is present; one-clock strobe |
| byte_data | input | 8 | Data byte qualified by byte_vld |
| stop_strobe | input | 1 | Closes the transfer; one-clock strobe |
| mem_we | output | 4 | Per-lane array write enables |
| mem_page | output | 5 | Page part of the array write address |
| mem_wdata | output | 32 | Lane bytes, lane i on bits 8*i+7..8*i |
| busy | output | 1 | High for the whole programming cycle |

## Verification
The bench sweeps three pages, all four start offsets and transfer lengths from zero to six bytes. It predicts each lane mask and lane byte arithmetically. This sweep covers wrap-around overwrite: a design that stopped at the page edge, or carried into the page bits, would write the wrong lane or the wrong page. The bench also times the busy window against PROG_CYCLES and places the single write clock inside it. A design that wrote lanes early, wrote them across several clocks, or started a cycle on an empty stop is caught here. Further transfers inject strobes while busy, send stray bytes with no open transfer, and restart a transfer part-way. Any leak of these into the buffer shows up as a wrong mask or a wrong byte at commit. Every committed write is also mirrored into a bench memory and compared against the model over all 128 addresses.

// File: rtl/pgwr_pkg.sv
// Package: shared types for the page write buffer.
// Assumes nothing beyond IEEE 1800-2017 packages.
package pgwr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_FILL = 2'd1,
        ST_PROG = 2'd2
    } pg_state_e;
endpackage

// File: rtl/pgwr_ptr.sv
// Address pointer: holds the page number fixed and steps the in-page
// offset modulo the page size. Assumes the page size is a power of two.
module pgwr_ptr #(
    parameter int ADDR_W = 7,
    parameter int OFF_W  = 2,
    parameter int PAGE_W = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              step,
    output logic [PAGE_W-1:0] page,
    output logic [OFF_W-1:0]  off
);
    // Load page/offset on start; advance offset only, wrapping naturally.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page <= '0;
            off  <= '0;
        end else if (load) begin
            page <= load_addr[ADDR_W-1:OFF_W];
            off  <= load_addr[OFF_W-1:0];
        end else if (step) begin
            off  <= off + 1'b1;
        end
    end
endmodule

// File: rtl/pgwr_lanes.sv
// Lane storage: one data register and one loaded flag per page byte.
// A write replaces the addressed lane; clear drops every loaded flag.
// Assumes clear and write are never asserted in the same clock.
module pgwr_lanes #(
    parameter int LANES  = 4,
    parameter int DATA_W = 8,
    parameter int OFF_W  = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr,
    input  logic                    wr,
    input  logic [OFF_W-1:0]        wr_off,
    input  logic [DATA_W-1:0]       wr_data,
    output logic [LANES-1:0]        vld,
    output logic [LANES*DATA_W-1:0] data
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic hit;
        assign hit = wr && (wr_off == OFF_W'(i));

        // Track whether lane i was loaded in the current transfer.
        always_ff @(posedge clk) begin
            if (!rst_n || clr) vld[i] <= 1'b0;
            else if (hit)      vld[i] <= 1'b1;
        end

        // Capture the newest byte aimed at lane i.
        always_ff @(posedge clk) begin
            if (!rst_n)   data[i*DATA_W +: DATA_W] <= '0;
            else if (hit) data[i*DATA_W +: DATA_W] <= wr_data;
        end
    end
endmodule

// File: rtl/pgwr_timer.sv
// Programming timer: once started, run is high for exactly CYCLES
// clocks and last marks the final one. Assumes CYCLES >= 1 and that
// start is only raised while run is low.
module pgwr_timer #(
    parameter int CYCLES = 20,
    parameter int CNT_W  = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic run,
    output logic last
);
    logic [CNT_W-1:0] cnt;

    // Count the remaining clocks of the cycle down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNT_W'(CYCLES - 1);
        end else if (run) begin
            if (cnt == '0) run <= 1'b0;
            else           cnt <= cnt - 1'b1;
        end
    end

    // Flag the final clock of the cycle.
    always_comb last = run && (cnt == '0);
endmodule

// File: rtl/pgwr_commit.sv
// Page write buffer with timed commit. Collects bytes of one page during
// a write transfer, then commits the loaded lanes in a single write at
// the end of a self-timed cycle. Assumes strobes are one clock wide;
// when several arrive in one clock, stop wins over start, and start wins
// over data.
module pgwr_commit #(
    parameter int ADDR_W      = 7,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 4,
    parameter int PROG_CYCLES = 20,
    localparam int OFF_W      = $clog2(PAGE_BYTES),
    localparam int PAGE_W     = ADDR_W - OFF_W
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_start,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic                         byte_vld,
    input  logic [DATA_W-1:0]            byte_data,
    input  logic                         stop_strobe,
    output logic [PAGE_BYTES-1:0]        mem_we,
    output logic [PAGE_W-1:0]            mem_page,
    output logic [PAGE_BYTES*DATA_W-1:0] mem_wdata,
    output logic                         busy
);
    import pgwr_pkg::*;

    pg_state_e             state;
    logic                  stop_acc, start_acc, byte_acc, go_prog;
    logic [OFF_W-1:0]      off;
    logic [PAGE_BYTES-1:0] vld;
    logic                  tmr_run, tmr_last;

    // Qualify the incoming strobes against the current state.
    always_comb begin
        stop_acc  = (state == ST_FILL) && stop_strobe;
        start_acc = (state != ST_PROG) && wr_start && !stop_acc;
        byte_acc  = (state == ST_FILL) && byte_vld && !stop_acc && !wr_start;
        go_prog   = stop_acc && (|vld);
    end

    // Transfer sequencing: idle, filling, programming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start_acc) state <= ST_FILL;
                ST_FILL: begin
                    if (go_prog)       state <= ST_PROG;
                    else if (stop_acc) state <= ST_IDLE;
                end
                ST_PROG: if (tmr_last) state <= ST_IDLE;
                default:               state <= ST_IDLE;
            endcase
        end
    end

    pgwr_ptr #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .PAGE_W (PAGE_W)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start_acc),
        .load_addr (wr_addr),
        .step      (byte_acc),
        .page      (mem_page),
        .off       (off)
    );

    pgwr_lanes #(
        .LANES  (PAGE_BYTES),
        .DATA_W (DATA_W),
        .OFF_W  (OFF_W)
    ) u_lanes (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (start_acc || tmr_last),
        .wr      (byte_acc),
        .wr_off  (off),
        .wr_data (byte_data),
        .vld     (vld),
        .data    (mem_wdata)
    );

    pgwr_timer #(
        .CYCLES (PROG_CYCLES)
    ) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (go_prog),
        .run   (tmr_run),
        .last  (tmr_last)
    );

    // Commit every loaded lane together in the last programming clock.
    always_comb begin
        busy   = tmr_run;
        mem_we = {PAGE_BYTES{tmr_last}} & vld;
    end
endmodule

// File: rtl/pgwr_commit_chk.sv
// Checker for pgwr_commit: relates the write enables, busy and the lane
// data over time. Counts the busy window itself rather than using deep
// $past, so a large PROG_CYCLES does not unroll.
module pgwr_commit_chk #(
    parameter int LANES       = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 20,
    localparam int LEN_W      = $clog2(PROG_CYCLES + 1) + 1
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    stop_strobe,
    input logic                    busy,
    input logic [LANES-1:0]        mem_we,
    input logic [LANES*DATA_W-1:0] mem_wdata
);
    logic [LEN_W-1:0] len;

    // Count the clocks busy has been high in the current window.
    always_ff @(posedge clk) begin
        if (!rst_n || !busy) len <= '0;
        else                 len <= len + 1'b1;
    end

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |-> busy); // R4
    AST_BUSY_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_strobe)); // R4
    AST_WE_ENDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (|mem_we) |=> !busy); // R5
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (len == LEN_W'(PROG_CYCLES))); // R5
    AST_BUSY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (len < LEN_W'(PROG_CYCLES))); // R5
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(mem_wdata)); // R8
endmodule

bind pgwr_commit pgwr_commit_chk #(
    .LANES       (PAGE_BYTES),
    .DATA_W      (DATA_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .stop_strobe (stop_strobe),
    .busy        (busy),
    .mem_we      (mem_we),
    .mem_wdata   (mem_wdata)
);

// File: tb/pgwr_commit_tb.sv
// Bench for pgwr_commit: sweeps pages, offsets and lengths, models the
// lane mask and data arithmetically, and mirrors commits into a memory.
module pgwr_commit_tb;
    localparam int CLK_PERIOD = 10;
    localparam int PROG       = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_start = 1'b0;
    logic [6:0]  wr_addr = '0;
    logic        byte_vld = 1'b0;
    logic [7:0]  byte_data = '0;
    logic        stop_strobe = 1'b0;
    logic [3:0]  mem_we;
    logic [4:0]  mem_page;
    logic [31:0] mem_wdata;
    logic        busy;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  done = 1'b0;
    logic [7:0] exp_mem [128];
    logic [7:0] obs_mem [128];

    always #(CLK_PERIOD/2) clk = ~clk;

    pgwr_commit #(.PROG_CYCLES(PROG)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_start(wr_start), .wr_addr(wr_addr),
        .byte_vld(byte_vld), .byte_data(byte_data), .stop_strobe(stop_strobe),
        .mem_we(mem_we), .mem_page(mem_page), .mem_wdata(mem_wdata), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] dval(input int addr, input int k);
        return 8'((addr * 7 + k * 29 + 3) & 255);
    endfunction

    // Open a transfer at addr and send n bytes (no stop).
    task automatic fill(input int addr, input int n, input int seed);
        @(negedge clk); wr_start = 1'b1; wr_addr = 7'(addr);
        @(negedge clk); wr_start = 1'b0;
        for (int k = 0; k < n; k++) begin
            byte_vld = 1'b1; byte_data = dval(seed, k);
            @(negedge clk);
            byte_vld = 1'b0;
            chk(busy == 1'b0 && mem_we == 4'd0, "R4 no write before stop", {busy, mem_we}, 0);
        end
    endtask

    // Full transfer with optional aborted prefix and busy-time injection.
    task automatic txn(input int addr, input int n, input bit inject,
                       input int pre_addr, input int pre_n);
        logic [3:0]  mask = '0;
        logic [31:0] lanes = '0;
        int          cyc;
        int          off;
        if (pre_n > 0) begin
            fill(pre_addr, pre_n, pre_addr + 1);
            @(negedge clk); wr_start = 1'b1; wr_addr = 7'(addr);
            @(negedge clk); wr_start = 1'b0;
            for (int k = 0; k < n; k++) begin
                byte_vld = 1'b1; byte_data = dval(addr, k);
                @(negedge clk);
                byte_vld = 1'b0;
            end
        end else begin
            fill(addr, n, addr);
        end
        for (int k = 0; k < n; k++) begin
            off = (addr + k) % 4;
            mask[off] = 1'b1;
            lanes[off*8 +: 8] = dval(addr, k);
        end
        stop_strobe = 1'b1;
        @(negedge clk);
        stop_strobe = 1'b0;
        if (n == 0) begin
            chk(busy == 1'b0 && mem_we == 4'd0, "R7 empty stop starts nothing", {busy, mem_we}, 0);
            repeat (3) @(negedge clk);
            chk(busy == 1'b0, "R7 busy stays low", busy, 0);
            return;
        end
        chk(busy == 1'b1, "R4 busy rises after stop", busy, 1);
        cyc = 1;
        while (busy && cyc <= PROG + 2) begin
            if (cyc == PROG) begin
                chk(mem_we == mask, (pre_n > 0) ? "R9 restart mask" :
                    (n == 1) ? "R10 single lane" : "R6 lane mask", mem_we, mask);
                chk(mem_page == 5'(addr >> 2), "R2 page fixed", mem_page, addr >> 2);
                for (int i = 0; i < 4; i++)
                    if (mask[i])
                        chk(mem_wdata[i*8 +: 8] == lanes[i*8 +: 8],
                            (n > 4) ? "R3 wrap overwrite" : inject ? "R8 data untouched" : "R2 lane data",
                            mem_wdata[i*8 +: 8], lanes[i*8 +: 8]);
                for (int i = 0; i < 4; i++)
                    if (mem_we[i]) obs_mem[{mem_page, 2'(i)}] = mem_wdata[i*8 +: 8];
                for (int i = 0; i < 4; i++)
                    if (mask[i]) exp_mem[((addr >> 2) << 2) + i] = lanes[i*8 +: 8];
            end else begin
                chk(mem_we == 4'd0, "R5 write only in last clock", mem_we, 0);
            end
            if (inject) begin
                wr_start    = (cyc == 3);
                wr_addr     = 7'(addr ^ 7'h55);
                byte_vld    = (cyc == 4);
                byte_data   = 8'hA5;
                stop_strobe = (cyc == 5);
            end
            @(negedge clk);
            wr_start = 1'b0; byte_vld = 1'b0; stop_strobe = 1'b0;
            cyc++;
        end
        chk(cyc - 1 == PROG, "R5 busy length", cyc - 1, PROG);
        repeat (2) @(negedge clk);
        chk(busy == 1'b0 && mem_we == 4'd0, inject ? "R8 nothing pending" : "R5 idle after commit",
            {busy, mem_we}, 0);
    endtask

    initial begin
        for (int a = 0; a < 128; a++) begin exp_mem[a] = 8'h00; obs_mem[a] = 8'h00; end
        repeat (3) @(negedge clk);
        chk(busy == 1'b0 && mem_we == 4'd0, "R1 reset state", {busy, mem_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0 && mem_we == 4'd0, "R1 after reset release", {busy, mem_we}, 0);

        foreach (exp_mem[p]) if (p == 0 || p == 5 || p == 31)
            for (int o = 0; o < 4; o++)
                for (int n = 0; n <= 6; n++)
                    txn(p * 4 + o, n, 1'b0, 0, 0);

        // R8: strobes during busy are ignored
        txn(7'h2D, 3, 1'b1, 0, 0);
        txn(7'h7F, 6, 1'b1, 0, 0);

        // R9: stray bytes with no open transfer
        @(negedge clk); byte_vld = 1'b1; byte_data = 8'h3C;
        @(negedge clk); byte_vld = 1'b0; stop_strobe = 1'b1;
        @(negedge clk); stop_strobe = 1'b0;
        chk(busy == 1'b0 && mem_we == 4'd0, "R9 stray bytes ignored", {busy, mem_we}, 0);

        // R9: restart discards earlier bytes
        txn(7'h41, 1, 1'b0, 7'h12, 3);
        txn(7'h66, 2, 1'b0, 7'h64, 2);
        // R10: single byte write
        txn(7'h0B, 1, 1'b0, 0, 0);

        for (int a = 0; a < 128; a++)
            chk(obs_mem[a] === exp_mem[a], "R2 array image", obs_mem[a], exp_mem[a]);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run did not finish)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule